// File: doc/BRIEF.md
# Escaped MFM Write Stream Formatter

This block sits between a byte source and an MFM bit encoder on the write path of a floppy controller. It turns a byte stream that carries in-band escape sequences into the raw byte sequence written to the track. Ordinary bytes pass through. The escape byte 0x99 makes the byte after it a command: emit a sync or index mark with a missing clock, insert the running CRC, open a window of raw bytes in which escapes are not decoded, or stop writing. A flag on the output tells the encoder which bytes get the missing-clock pattern.

Both stream sides use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. The output holds one byte. While that byte waits for `out_ready`, the byte and its flag stay stable and `in_ready` stays low. After a CRC command, `in_ready` also stays low until the CRC low byte has been loaded. Two sticky flags, cleared only by reset, report an undefined command code and a starved input stream.

A typical sector write stream is: gap bytes 0x4E, zero sync bytes, three escaped A1 marks, the data mark 0xFB, the raw-window command followed by the sector bytes, then insert-CRC, a few 0x4E gap bytes and the stop command.

Top module: `escwr_formatter`

## Requirements
- R1: An input byte other than 0x99 that arrives outside an escape is emitted once, unchanged, in input order, with `out_mark` = 0.
- R2: The pair 0x99 0xA1 emits 0xA1 with `out_mark` = 1. The pair 0x99 0xC2 emits 0xC2 with `out_mark` = 1. Neither the escape byte nor the code byte is ever emitted as data.
- R3: The pair 0x99 0x0F emits nothing. The next RAW_LEN input bytes (default 512) are emitted verbatim with `out_mark` = 0, including 0x99 and any code values. Escape decoding resumes on the byte after them.
- R4: The CRC is CRC-16 with polynomial 0x1021, shifted MSB first. It is preset to 0xFFFF when an A1 mark is emitted and the previously emitted byte was not an A1 mark. Every emitted byte except the CRC bytes themselves then updates it, and that includes the marks.
- R5: The pair 0x99 0x04 emits the current CRC as two bytes, high byte first, both with `out_mark` = 0.
- R6: `writing` goes to 1 when a byte is accepted while it is 0. The pair 0x99 0x08 emits nothing and returns `writing` to 0.
- R7: An escape followed by any code other than A1, C2, 0F, 04 or 08 drops the code byte, emits nothing and sets the sticky `code_err`.
- R8: If `writing` is 1, `in_ready` is 1 and `in_valid` is 0 in a cycle, the sticky `underrun` is set.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_mark` hold and `in_ready` is 0. Back-pressure loses or duplicates no byte.
- R10: After reset, `out_valid`, `writing`, `code_err` and `underrun` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Escaped input byte |
| in_ready | output | 1 | Formatter can take a byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Byte to record |
| out_mark | output | 1 | Byte needs the missing-clock pattern |
| out_ready | input | 1 | Encoder takes the output byte |
| writing | output | 1 | A write stream is in progress |
| code_err | output | 1 | Sticky: undefined escape code seen |
| underrun | output | 1 | Sticky: input starved while writing |

## Verification
The assertions check the cycle-level rules on every cycle: the output byte is held under back-pressure, no input is accepted while the slot is full, marked bytes are only A1 or C2, and the two error flags stay set once raised. Only the bench scenarios can show what the stream actually contains. That means the CRC values after a mark group restarts, the exact edges of the raw window where 0x99 and 0x08 must pass through, the two-byte CRC order, and that no byte is lost or repeated when `out_ready` toggles.

// File: rtl/escwr_pkg.sv
package escwr_pkg;
  localparam logic [7:0] ESC_BYTE  = 8'h99;
  localparam logic [7:0] CODE_SYNC = 8'hA1;
  localparam logic [7:0] CODE_IDX  = 8'hC2;
  localparam logic [7:0] CODE_CRC  = 8'h04;
  localparam logic [7:0] CODE_STOP = 8'h08;
  localparam logic [7:0] CODE_RAW  = 8'h0F;

  typedef enum logic [2:0] {
    CMD_SYNC, CMD_IDX, CMD_CRC, CMD_STOP, CMD_RAW, CMD_BAD
  } esc_cmd_e;

  function automatic esc_cmd_e decode_code(input logic [7:0] c);
    case (c)
      CODE_SYNC: return CMD_SYNC;
      CODE_IDX:  return CMD_IDX;
      CODE_CRC:  return CMD_CRC;
      CODE_STOP: return CMD_STOP;
      CODE_RAW:  return CMD_RAW;
      default:   return CMD_BAD;
    endcase
  endfunction

  function automatic logic [15:0] crc_byte_step(input logic [15:0] crc,
                                                input logic [7:0] d,
                                                input logic [15:0] poly);
    logic [15:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ poly;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/escwr_crc.sv
module escwr_crc #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             update,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc
);
  import escwr_pkg::*;

  logic [15:0] base;
  assign base = restart ? SEED : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= SEED;
    else if (update) crc <= crc_byte_step(base, din, POLY);
  end
endmodule

// File: rtl/escwr_raw_window.sv
module escwr_raw_window #(
  parameter int RAW_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_win,
  input  logic take,
  output logic raw_on
);
  localparam int CW = $clog2(RAW_LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(RAW_LEN);

  logic [CW-1:0] left;
  assign raw_on = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (open_win)      left <= LEN_V;
    else if (take && raw_on) left <= left - 1'b1;
  end
endmodule

// File: rtl/escwr_out_stage.sv
module escwr_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_mark,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_mark,
  output logic          slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mark  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_mark  <= load_mark;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/escwr_formatter.sv
module escwr_formatter #(
  parameter int          RAW_LEN  = 512,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_mark,
  input  logic       out_ready,
  output logic       writing,
  output logic       code_err,
  output logic       underrun
);
  import escwr_pkg::*;

  localparam int CRC_W = 16;

  logic             slot_free, raw_on, accept;
  logic             esc_pend, crc_lo_pend, last_sync;
  logic [CRC_W-1:0] crc;
  logic             emit, emit_mark, emit_is_crc;
  logic [7:0]       emit_data;
  logic             set_esc, clr_esc, set_lo, clr_lo, open_win, take_raw;
  logic             stop_seen, bad_seen;
  esc_cmd_e         cmd;

  assign in_ready = slot_free && !crc_lo_pend;
  assign accept   = in_valid && in_ready;
  assign cmd      = decode_code(in_data);

  always_comb begin
    emit        = 1'b0;
    emit_mark   = 1'b0;
    emit_is_crc = 1'b0;
    emit_data   = in_data;
    set_esc     = 1'b0;
    clr_esc     = 1'b0;
    set_lo      = 1'b0;
    clr_lo      = 1'b0;
    open_win    = 1'b0;
    take_raw    = 1'b0;
    stop_seen   = 1'b0;
    bad_seen    = 1'b0;
    if (crc_lo_pend) begin
      if (slot_free) begin
        emit        = 1'b1;
        emit_is_crc = 1'b1;
        emit_data   = crc[7:0];
        clr_lo      = 1'b1;
      end
    end else if (accept) begin
      if (raw_on) begin
        emit     = 1'b1;
        take_raw = 1'b1;
      end else if (esc_pend) begin
        clr_esc = 1'b1;
        unique case (cmd)
          CMD_SYNC, CMD_IDX: begin
            emit      = 1'b1;
            emit_mark = 1'b1;
          end
          CMD_CRC: begin
            emit        = 1'b1;
            emit_is_crc = 1'b1;
            emit_data   = crc[15:8];
            set_lo      = 1'b1;
          end
          CMD_RAW:  open_win  = 1'b1;
          CMD_STOP: stop_seen = 1'b1;
          default:  bad_seen  = 1'b1;
        endcase
      end else if (in_data == ESC_BYTE) begin
        set_esc = 1'b1;
      end else begin
        emit = 1'b1;
      end
    end
  end

  logic crc_restart;
  assign crc_restart = emit && emit_mark && (emit_data == CODE_SYNC) && !last_sync;

  escwr_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (crc_restart),
    .update  (emit && !emit_is_crc),
    .din     (emit_data),
    .crc     (crc)
  );

  escwr_raw_window #(.RAW_LEN(RAW_LEN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_win (open_win),
    .take     (take_raw),
    .raw_on   (raw_on)
  );

  escwr_out_stage #(.DW(8)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_data (emit_data),
    .load_mark (emit_mark),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_mark  (out_mark),
    .slot_free (slot_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_pend    <= 1'b0;
      crc_lo_pend <= 1'b0;
      last_sync   <= 1'b0;
      writing     <= 1'b0;
      code_err    <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      if (set_esc)      esc_pend <= 1'b1;
      else if (clr_esc) esc_pend <= 1'b0;
      if (set_lo)       crc_lo_pend <= 1'b1;
      else if (clr_lo)  crc_lo_pend <= 1'b0;
      if (emit)         last_sync <= emit_mark && (emit_data == CODE_SYNC);
      if (accept)       writing <= !stop_seen;
      if (bad_seen)     code_err <= 1'b1;
      if (writing && in_ready && !in_valid) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/escwr_checker.sv
module escwr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_mark,
  input logic       out_ready,
  input logic       code_err,
  input logic       underrun
);
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mark)));

  a_r9_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r2_mark_values: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mark) |-> (out_data == 8'hA1 || out_data == 8'hC2));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);

  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
endmodule

bind escwr_formatter escwr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_mark  (out_mark),
  .out_ready (out_ready),
  .code_err  (code_err),
  .underrun  (underrun)
);

// File: tb/escwr_formatter_tb.sv
`timescale 1ns/1ps
module escwr_formatter_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_mark, out_ready = 1;
  logic [7:0] in_data = 0, out_data;
  logic writing, code_err, underrun;
  logic bp = 0;
  int cyc = 0;
  int checks = 0, failures = 0;

  logic [7:0] src [0:700];
  int nsrc = 0;
  logic [8:0] expv [0:700];
  int nexp = 0;
  logic [8:0] cap [0:700];
  int ncap = 0;

  always #5 clk = ~clk;

  escwr_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_mark(out_mark), .out_ready(out_ready), .writing(writing),
    .code_err(code_err), .underrun(underrun));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    out_ready <= bp ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && ncap <= 700) begin
      cap[ncap] = {out_mark, out_data};
      ncap++;
    end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    repeat (8) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic s(input logic [7:0] b); src[nsrc] = b; nsrc++; endtask
  task automatic e(input logic [7:0] b, input logic m); expv[nexp] = {m, b}; nexp++; endtask

  task automatic do_reset();
    in_valid = 0; bp = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    nsrc = 0; nexp = 0; ncap = 0;
  endtask

  task automatic push_all();
    for (int i = 0; i < nsrc; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = src[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk) in_valid = 0;
  endtask

  task automatic compare(input string req);
    int bad = 0, first = -1;
    repeat (20) @(negedge clk);
    chk(ncap == nexp, {req, " count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      if (cap[i] !== expv[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1, req, 0, 0);
    else chk(0, {req, " content"}, cap[first], expv[first]);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R10 outputs", {out_valid, in_ready}, 2'b01);
    chk(writing == 0 && code_err == 0 && underrun == 0, "R10 flags",
        {writing, code_err, underrun}, 0);
  endtask

  task automatic id_stream(input bit with_bp);
    logic [15:0] c;
    do_reset();
    bp = with_bp;
    s(8'h4E); s(8'h4E); s(8'h00); s(8'h99); s(8'hC2);
    e(8'h4E, 0); e(8'h4E, 0); e(8'h00, 0); e(8'hC2, 1);
    for (int k = 0; k < 3; k++) begin s(8'h99); s(8'hA1); e(8'hA1, 1); end
    s(8'hFE); e(8'hFE, 0);
    c = 16'hFFFF;
    c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hFE);
    s(8'h99); s(8'h04); e(c[15:8], 0); e(c[7:0], 0);
    s(8'h4E); e(8'h4E, 0);
    s(8'h99); s(8'h08);
    push_all();
    compare(with_bp ? "R9 backpressure stream" : "R1 R2 R5 id stream");
    chk(writing == 0, "R6 stop", writing, 0);
    chk(underrun == 0 && code_err == 0, "R8 R7 no flags after stop", {underrun, code_err}, 0);
  endtask

  task automatic t_raw();
    logic [15:0] c;
    logic [7:0] d;
    do_reset();
    c = 16'hFFFF;
    for (int k = 0; k < 3; k++) begin s(8'h99); s(8'hA1); e(8'hA1, 1); c = ref_crc(c, 8'hA1); end
    s(8'hFB); e(8'hFB, 0); c = ref_crc(c, 8'hFB);
    s(8'h99); s(8'h0F);
    for (int i = 0; i < 512; i++) begin
      d = (i == 0) ? 8'h99 : (i == 1) ? 8'h08 : 8'((i * 37 + 5) & 255);
      s(d); e(d, 0); c = ref_crc(c, d);
    end
    s(8'h99); s(8'h04); e(c[15:8], 0); e(c[7:0], 0);
    s(8'h99); s(8'h08);
    push_all();
    compare("R3 R4 raw window and crc");
    chk(writing == 0, "R3 escape resumes after window", writing, 0);
  endtask

  task automatic t_crc_restart();
    logic [15:0] c;
    do_reset();
    s(8'h99); s(8'hA1); s(8'h99); s(8'hA1); s(8'hFE); s(8'h99); s(8'h04);
    e(8'hA1, 1); e(8'hA1, 1); e(8'hFE, 0);
    c = ref_crc(ref_crc(ref_crc(16'hFFFF, 8'hA1), 8'hA1), 8'hFE);
    e(c[15:8], 0); e(c[7:0], 0);
    s(8'h99); s(8'hA1); s(8'h33); s(8'h99); s(8'h04);
    e(8'hA1, 1); e(8'h33, 0);
    c = ref_crc(ref_crc(16'hFFFF, 8'hA1), 8'h33);
    e(c[15:8], 0); e(c[7:0], 0);
    s(8'h99); s(8'h08);
    push_all();
    compare("R4 crc preset per mark group");
  endtask

  task automatic t_bad_code();
    do_reset();
    s(8'h99); s(8'h55); s(8'h11); s(8'h99); s(8'h08);
    e(8'h11, 0);
    push_all();
    compare("R7 undefined code dropped");
    chk(code_err == 1, "R7 code_err set", code_err, 1);
    chk(underrun == 0, "R7 no underrun", underrun, 0);
  endtask

  task automatic t_underrun();
    do_reset();
    s(8'h12);
    e(8'h12, 0);
    push_all();
    repeat (3) @(negedge clk);
    chk(writing == 1, "R6 writing active", writing, 1);
    chk(underrun == 1, "R8 underrun set", underrun, 1);
    compare("R1 byte before underrun");
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    id_stream(0);
    id_stream(1);
    t_raw();
    t_crc_restart();
    t_bad_code();
    t_underrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule